// File: doc/BRIEF.md
# Serial Hex Command Monitor

This block is a small line-based command interpreter. It sits between a byte receiver and a byte transmitter. Before each entry it sends a new-line pair and a `>` prompt. It then takes exactly one entry from the incoming byte stream and reads it as a selector character followed by hexadecimal digits.

The selector decides what happens to the value:
- A `W` turns the value into a code address. The block raises an execute request for it and waits for the routine to report completion.
- Any other selector pushes the value onto an internal data stack.

The stack's depth, its top entry and a sticky overflow flag are visible at the ports. A routine started by an execute request can inspect these outputs.

There is no word dictionary. A routine is named only by its numeric address. Digits are read until a character that is not a hex digit appears. That character ends the conversion silently, and the digits already read still form the value.

Top module: `hexmon_top`

## Requirements
- R1: Before each entry the transmitter presents the bytes 0x0D, 0x0A and 0x3E ('>') in that order. No received byte is accepted (rx_ready low) until the last prompt byte has been taken.
- R2: If the first byte of a line is 0x57 ('W'), exec_req rises with exec_addr equal to the converted value. Both stay unchanged until exec_done is seen high.
- R3: If the first byte is any other non-terminator value, the converted value is pushed: push_strobe pulses for one cycle with push_value equal to it, and no execute request is made.
- R4: Digits 0x30-0x39, 0x41-0x46 and 0x61-0x66 are hexadecimal (0-9, A-F, a-f). Each digit updates the 16-bit accumulator to ((acc << 4) | digit) mod 2^16, so only the last four digits survive.
- R5: The first non-hex byte after the selector ends the conversion. Later digits on the same line have no effect on the value.
- R6: A line ends on 0x0D or 0x00. A line whose first byte is a terminator pushes the value 0.
- R7: After exec_done, the block starts a fresh prompt. While an execute request is pending, the block neither accepts bytes nor transmits.
- R8: The stack holds up to 50 entries. Each accepted push raises stack_depth by one and shows the pushed value on stack_top.
- R9: A push while stack_depth is 50 is dropped: depth and top are unchanged and stack_ovf is set. stack_ovf stays set until reset.
- R10: During and after reset, stack_depth is 0, stack_ovf is 0, exec_req and push_strobe are low, rx_ready is low, and tx_valid is high with tx_data 0x0D.
- R11: A prompt byte that is not accepted (tx_ready low) stays on tx_data with tx_valid high. Stalls on the transmit side do not corrupt the prompt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Monitor takes the received byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte |
| push_strobe | output | 1 | One-cycle push of a number entry |
| push_value | output | 16 | Value being pushed |
| stack_depth | output | 6 | Number of entries on the data stack |
| stack_top | output | 16 | Most recent entry, 0 when empty |
| stack_ovf | output | 1 | Sticky flag: a push found the stack full |
| exec_req | output | 1 | Execute request pending |
| exec_addr | output | 16 | Code address to execute |
| exec_done | input | 1 | Executed routine has finished |

## Verification
The hold checks assume a well-behaved environment on three points:
- exec_done is raised only while exec_req is high.
- A received byte is held on rx_data until rx_ready takes it.
- tx_ready may stall freely.

The stimulus meets these conditions by construction. A responder raises exec_done only after it has seen exec_req for a chosen number of cycles. Bytes are offered from a task that keeps them steady until the handshake. One phase of the test toggles tx_ready every cycle, so that prompt bytes are stalled.

// File: rtl/hexmon_pkg.sv
package hexmon_pkg;

   localparam logic [7:0] CH_CR     = 8'h0D;
   localparam logic [7:0] CH_LF     = 8'h0A;
   localparam logic [7:0] CH_NUL    = 8'h00;
   localparam logic [7:0] CH_PROMPT = 8'h3E;
   localparam logic [7:0] CH_EXEC   = 8'h57;

   typedef enum logic [2:0] {
      ST_PROMPT,
      ST_FIRST,
      ST_DIGITS,
      ST_DISPATCH,
      ST_EXEC
   } mon_state_t;

   typedef struct packed {
      logic       ok;
      logic [3:0] nib;
   } nibble_t;

   // Upper-case and decimal digit decode
   function automatic nibble_t decode_upper(input logic [7:0] c);
      nibble_t r;
      r.ok  = 1'b0;
      r.nib = 4'h0;
      if (c >= 8'h30 && c <= 8'h39) begin
         r.ok  = 1'b1;
         r.nib = c[3:0];
      end else if (c >= 8'h41 && c <= 8'h46) begin
         r.ok  = 1'b1;
         r.nib = c[3:0] + 4'd9;
      end
      return r;
   endfunction

   function automatic logic is_term(input logic [7:0] c);
      return (c == CH_CR) || (c == CH_NUL);
   endfunction

endpackage

// File: rtl/hexmon_prompt.sv
module hexmon_prompt
   import hexmon_pkg::*;
#(
   parameter bit CRLF = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       tx_ready,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   output logic       done
);

   localparam int          LEN  = CRLF ? 3 : 2;
   localparam logic [1:0]  LAST = 2'(LEN - 1);

   logic [1:0] idx;

   generate
      if (CRLF) begin : g_crlf
         always_comb begin
            case (idx)
               2'd0:    tx_data = CH_CR;
               2'd1:    tx_data = CH_LF;
               default: tx_data = CH_PROMPT;
            endcase
         end
      end else begin : g_lf
         always_comb begin
            case (idx)
               2'd0:    tx_data = CH_LF;
               default: tx_data = CH_PROMPT;
            endcase
         end
      end
   endgenerate

   assign tx_valid = active;
   assign done     = active && tx_ready && (idx == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= 2'd0;
      end else if (!active) begin
         idx <= 2'd0;
      end else if (tx_ready) begin
         idx <= done ? 2'd0 : idx + 2'd1;
      end
   end

endmodule

// File: rtl/hexmon_conv.sv
module hexmon_conv
   import hexmon_pkg::*;
#(
   parameter int VAL_W    = 16,
   parameter bit LOWER_OK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             feed,
   input  logic [7:0]       ch,
   output logic [VAL_W-1:0] value
);

   nibble_t dec;
   logic    stopped;

   generate
      if (LOWER_OK) begin : g_any_case
         always_comb begin
            dec = decode_upper(ch);
            if (ch >= 8'h61 && ch <= 8'h66) begin
               dec.ok  = 1'b1;
               dec.nib = ch[3:0] + 4'd9;
            end
         end
      end else begin : g_upper_only
         always_comb dec = decode_upper(ch);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value   <= '0;
         stopped <= 1'b0;
      end else if (clear) begin
         value   <= '0;
         stopped <= 1'b0;
      end else if (feed) begin
         if (!stopped && dec.ok) begin
            value <= {value[VAL_W-5:0], dec.nib};
         end else begin
            stopped <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/hexmon_stack.sv
module hexmon_stack #(
   parameter  int DEPTH = 50,
   parameter  int VAL_W = 16,
   localparam int DW    = $clog2(DEPTH + 1),
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [VAL_W-1:0] din,
   output logic [DW-1:0]    depth,
   output logic [VAL_W-1:0] top,
   output logic             ovf
);

   localparam logic [DW-1:0] FULL = DW'(DEPTH);

   logic [VAL_W-1:0] mem [DEPTH];
   logic             full;
   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    rd_ptr;

   assign full   = (depth == FULL);
   assign wr_ptr = AW'(depth);
   assign rd_ptr = AW'(depth - 1'b1);
   assign top    = (depth == '0) ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         depth <= '0;
         ovf   <= 1'b0;
      end else if (push) begin
         if (full) ovf   <= 1'b1;
         else      depth <= depth + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[wr_ptr] <= din;
   end

endmodule

// File: rtl/hexmon_top.sv
module hexmon_top
   import hexmon_pkg::*;
#(
   parameter  int STK_DEPTH = 50,
   parameter  int VAL_W     = 16,
   parameter  bit LOWER_OK  = 1'b1,
   parameter  bit CRLF      = 1'b1,
   localparam int DW        = $clog2(STK_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   output logic             rx_ready,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   input  logic             tx_ready,
   output logic             push_strobe,
   output logic [VAL_W-1:0] push_value,
   output logic [DW-1:0]    stack_depth,
   output logic [VAL_W-1:0] stack_top,
   output logic             stack_ovf,
   output logic             exec_req,
   output logic [VAL_W-1:0] exec_addr,
   input  logic             exec_done
);

   generate
      if (VAL_W < 4 || (VAL_W % 4) != 0) begin : g_bad_width
         $error("hexmon_top: VAL_W must be a positive multiple of 4");
      end
      if (STK_DEPTH < 1) begin : g_bad_depth
         $error("hexmon_top: STK_DEPTH must be at least 1");
      end
   endgenerate

   mon_state_t       state, state_nx;
   logic             exec_mode;
   logic             rx_fire;
   logic             rx_term;
   logic             prompt_done;
   logic             conv_clear;
   logic             conv_feed;
   logic [VAL_W-1:0] conv_value;

   assign rx_ready   = (state == ST_FIRST) || (state == ST_DIGITS);
   assign rx_fire    = rx_valid && rx_ready;
   assign rx_term    = is_term(rx_data);
   assign conv_clear = (state == ST_FIRST);
   assign conv_feed  = (state == ST_DIGITS) && rx_fire && !rx_term;

   hexmon_prompt #(.CRLF(CRLF)) u_prompt (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (state == ST_PROMPT),
      .tx_ready (tx_ready),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .done     (prompt_done)
   );

   hexmon_conv #(.VAL_W(VAL_W), .LOWER_OK(LOWER_OK)) u_conv (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (conv_clear),
      .feed  (conv_feed),
      .ch    (rx_data),
      .value (conv_value)
   );

   hexmon_stack #(.DEPTH(STK_DEPTH), .VAL_W(VAL_W)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_strobe),
      .din   (conv_value),
      .depth (stack_depth),
      .top   (stack_top),
      .ovf   (stack_ovf)
   );

   always_comb begin
      state_nx = state;
      case (state)
         ST_PROMPT:   if (prompt_done) state_nx = ST_FIRST;
         ST_FIRST:    if (rx_fire) state_nx = rx_term ? ST_DISPATCH : ST_DIGITS;
         ST_DIGITS:   if (rx_fire && rx_term) state_nx = ST_DISPATCH;
         ST_DISPATCH: state_nx = exec_mode ? ST_EXEC : ST_PROMPT;
         ST_EXEC:     if (exec_done) state_nx = ST_PROMPT;
         default:     state_nx = ST_PROMPT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_PROMPT;
         exec_mode <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_FIRST && rx_fire) begin
            exec_mode <= !rx_term && (rx_data == CH_EXEC);
         end
      end
   end

   assign push_strobe = (state == ST_DISPATCH) && !exec_mode;
   assign push_value  = conv_value;
   assign exec_req    = (state == ST_EXEC);
   assign exec_addr   = conv_value;

endmodule

// File: rtl/hexmon_checker.sv
module hexmon_checker #(
   parameter int STK_DEPTH = 50,
   parameter int VAL_W     = 16,
   parameter bit CRLF      = 1'b1,
   parameter int DW        = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_ready,
   input logic             tx_valid,
   input logic [7:0]       tx_data,
   input logic             tx_ready,
   input logic             push_strobe,
   input logic [DW-1:0]    stack_depth,
   input logic [VAL_W-1:0] stack_top,
   input logic             stack_ovf,
   input logic             exec_req,
   input logic [VAL_W-1:0] exec_addr,
   input logic             exec_done
);

   localparam logic [DW-1:0] FULL  = DW'(STK_DEPTH);
   localparam logic [7:0]    FIRST = CRLF ? 8'h0D : 8'h0A;

   AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      stack_depth <= FULL); // R8

   AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      push_strobe && stack_depth < FULL |=> stack_depth == $past(stack_depth) + 1'b1); // R8

   AST_DEPTH_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !push_strobe |=> $stable(stack_depth)); // R8

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      push_strobe && stack_depth == FULL |=> stack_ovf && $stable(stack_depth) && $stable(stack_top)); // R9

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stack_ovf |=> stack_ovf); // R9

   AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      exec_req && !exec_done |=> exec_req && $stable(exec_addr)); // R2

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R11

   AST_BUSY_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_req || tx_valid) |-> !rx_ready); // R7

   AST_EXEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      exec_req |-> !tx_valid); // R7

   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_strobe && exec_req)); // R3

   AST_DONE_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
      exec_req && exec_done |=> tx_valid && tx_data == FIRST); // R7

endmodule

bind hexmon_top hexmon_checker #(
   .STK_DEPTH (STK_DEPTH),
   .VAL_W     (VAL_W),
   .CRLF      (CRLF),
   .DW        (DW)
) u_hexmon_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_ready    (rx_ready),
   .tx_valid    (tx_valid),
   .tx_data     (tx_data),
   .tx_ready    (tx_ready),
   .push_strobe (push_strobe),
   .stack_depth (stack_depth),
   .stack_top   (stack_top),
   .stack_ovf   (stack_ovf),
   .exec_req    (exec_req),
   .exec_addr   (exec_addr),
   .exec_done   (exec_done)
);

// File: tb/test_hexmon_top.sv
module test_hexmon_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        rx_ready;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b1;
   logic        push_strobe;
   logic [15:0] push_value;
   logic [5:0]  stack_depth;
   logic [15:0] stack_top;
   logic        stack_ovf;
   logic        exec_req;
   logic [15:0] exec_addr;
   logic        exec_done = 1'b0;

   always #10 clk = ~clk;

   hexmon_top i_hexmon_top (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_valid    (rx_valid),
      .rx_data     (rx_data),
      .rx_ready    (rx_ready),
      .tx_valid    (tx_valid),
      .tx_data     (tx_data),
      .tx_ready    (tx_ready),
      .push_strobe (push_strobe),
      .push_value  (push_value),
      .stack_depth (stack_depth),
      .stack_top   (stack_top),
      .stack_ovf   (stack_ovf),
      .exec_req    (exec_req),
      .exec_addr   (exec_addr),
      .exec_done   (exec_done)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // Environment models, all acting at the falling edge
   logic [7:0]  txlog [0:4095];
   int          txn = 0;
   int          pushn = 0;
   logic [15:0] push_last = 16'h0;
   int          execn = 0;
   logic [15:0] exec_last = 16'h0;
   int          exec_delay = 2;
   int          ecnt = 0;
   bit          stall = 1'b0;

   always @(negedge clk) begin
      tx_ready = stall ? ~tx_ready : 1'b1;
      if (rst_n) begin
         if (tx_valid && tx_ready && txn < 4096) begin
            txlog[txn] = tx_data;
            txn++;
         end
         if (push_strobe) begin
            push_last = push_value;
            pushn++;
         end
         if (exec_req && !exec_done) begin
            ecnt++;
            if (ecnt >= exec_delay) begin
               exec_done = 1'b1;
               exec_last = exec_addr;
               execn++;
               ecnt = 0;
            end
         end else begin
            exec_done = 1'b0;
         end
      end else begin
         exec_done = 1'b0;
         ecnt = 0;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic send_line(input logic [63:0] s, input logic [7:0] term);
      bit         started = 1'b0;
      logic [7:0] b;
      for (int i = 7; i >= 0; i--) begin
         b = s[i*8 +: 8];
         if (b != 8'h00) started = 1'b1;
         if (started) send_byte(b);
      end
      send_byte(term);
   endtask

   task automatic wait_idle();
      int k = 0;
      @(negedge clk);
      while (!rx_ready && k < 2000) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic chk_prompt(input string tag, input int t0);
      chk({tag, " prompt count"}, txn - t0, 3);
      chk({tag, " prompt CR"}, int'(txlog[t0]), 8'h0D);
      chk({tag, " prompt LF"}, int'(txlog[t0+1]), 8'h0A);
      chk({tag, " prompt >"}, int'(txlog[t0+2]), 8'h3E);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   typedef struct packed {
      logic [63:0] line;
      logic        ex;
      logic [15:0] val;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{64'("N1234"),  1'b0, 16'h1234},   // R3 R4
      '{64'("Wbeef"),  1'b1, 16'hBEEF},   // R2 R4 lower case
      '{64'("N12345"), 1'b0, 16'h2345},   // R4 overflow keeps low digits
      '{64'("Nab"),    1'b0, 16'h00AB},   // R4
      '{64'("N7G9"),   1'b0, 16'h0007},   // R5
      '{64'("W"),      1'b1, 16'h0000},   // R2 no digits
      '{64'("X00FF"),  1'b0, 16'h00FF},   // R3 other selector
      '{64'("N"),      1'b0, 16'h0000},   // R3
      '{64'("WFEE4"),  1'b1, 16'hFEE4},   // R2
      '{64'("N-5"),    1'b0, 16'h0000}    // R5
   };

   initial begin
      int t0, p0, e0, depth_exp;
      depth_exp = 0;

      // R10 reset state
      repeat (3) @(negedge clk);
      chk("R10 depth", int'(stack_depth), 0);
      chk("R10 ovf", int'(stack_ovf), 0);
      chk("R10 exec_req", int'(exec_req), 0);
      chk("R10 push_strobe", int'(push_strobe), 0);
      chk("R10 rx_ready", int'(rx_ready), 0);
      chk("R10 tx_valid", int'(tx_valid), 1);
      chk("R10 tx_data", int'(tx_data), 8'h0D);
      rst_n = 1'b1;

      // R1 first prompt
      t0 = txn;
      wait_idle();
      chk_prompt("R1", t0);

      // Table of entries
      for (int v = 0; v < NV; v++) begin
         t0 = txn; p0 = pushn; e0 = execn;
         send_line(VECS[v].line, 8'h0D);
         wait_idle();
         if (VECS[v].ex) begin
            chk("R2 exec count", execn - e0, 1);
            chk("R2 exec addr", int'(exec_last), int'(VECS[v].val));
            chk("R2 no push", pushn - p0, 0);
         end else begin
            depth_exp++;
            chk("R3 push count", pushn - p0, 1);
            chk("R4 R5 push value", int'(push_last), int'(VECS[v].val));
            chk("R8 top", int'(stack_top), int'(VECS[v].val));
            chk("R8 depth", int'(stack_depth), depth_exp);
            chk("R3 no exec", execn - e0, 0);
         end
         chk_prompt("R7 R1", t0);
      end

      // R6 empty line and NUL terminator
      p0 = pushn;
      send_byte(8'h00);
      wait_idle();
      depth_exp++;
      chk("R6 empty line push", pushn - p0, 1);
      chk("R6 empty value", int'(stack_top), 0);
      send_line(64'("N5A"), 8'h00);
      wait_idle();
      depth_exp++;
      chk("R6 NUL terminated", int'(stack_top), 16'h005A);
      chk("R8 depth after R6", int'(stack_depth), depth_exp);

      // R7 pending execute blocks input and output
      exec_delay = 8;
      t0 = txn;
      send_line(64'("W0100"), 8'h0D);
      while (!exec_req) @(negedge clk);
      chk("R2 pending addr", int'(exec_addr), 16'h0100);
      repeat (3) begin
         @(negedge clk);
         chk("R7 rx blocked", int'(rx_ready), 0);
         chk("R7 tx quiet", int'(tx_valid), 0);
         chk("R2 req held", int'(exec_req), 1);
      end
      chk("R7 nothing sent while busy", txn - t0, 0);
      wait_idle();
      chk_prompt("R7", t0);
      exec_delay = 2;

      // R11 transmit stalls
      stall = 1'b1;
      t0 = txn;
      send_line(64'("N0C0D"), 8'h0D);
      wait_idle();
      chk_prompt("R11", t0);
      chk("R11 value", int'(stack_top), 16'h0C0D);
      stall = 1'b0;

      // R9 fill the stack after a fresh reset
      do_reset();
      chk("R10 depth after reset", int'(stack_depth), 0);
      rst_n = 1'b1;
      wait_idle();
      for (int i = 0; i < 50; i++) begin
         send_byte(8'h4E);
         send_byte(8'h30 + 8'(i / 10));
         send_byte(8'h30 + 8'(i % 10));
         send_byte(8'h0D);
         wait_idle();
      end
      chk("R8 full depth", int'(stack_depth), 50);
      chk("R8 full top", int'(stack_top), 16'h0049);
      chk("R9 no ovf yet", int'(stack_ovf), 0);
      p0 = pushn;
      send_line(64'("NAAAA"), 8'h0D);
      wait_idle();
      chk("R9 push seen", pushn - p0, 1);
      chk("R9 depth kept", int'(stack_depth), 50);
      chk("R9 top kept", int'(stack_top), 16'h0049);
      chk("R9 ovf set", int'(stack_ovf), 1);
      send_line(64'("WCAFE"), 8'h0D);
      wait_idle();
      chk("R9 ovf sticky", int'(stack_ovf), 1);
      do_reset();
      chk("R9 R10 ovf cleared", int'(stack_ovf), 0);
      chk("R10 depth cleared", int'(stack_depth), 0);
      rst_n = 1'b1;

      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

endmodule